// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Vectoring Controller

This block arbitrates seven interrupt sources on behalf of a small 8-bit microcontroller core. On every machine-cycle strobe it takes the request flags that it registered on the strobe before. It masks them with a global enable and per-source enables and splits them into a high and a low priority level. When the core reports that the current cycle may accept an interrupt, the block issues a one-cycle hardware call request carrying a 16-bit vector address.

The block keeps one in-progress flag per priority level. A flag is set when a source of that level is vectored and cleared when the core finishes an interrupt-return instruction. While a level is in progress, requests of that level and of lower levels are held off. Alongside the call it gives the core a one-hot acknowledge for the granted source and a one-hot flag-clear strobe, which is driven only for the sources whose flags are cleared in hardware.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A granted source with index i (0 ext0, 1 tmr0, 2 ext1, 3 tmr1, 4 serial, 5 timer 2, 6 counter array) produces `call_vec` = 0x0003 + 8*i together with `call_req` high for exactly one clock, in the clock after the deciding strobe.
- R2: No call is issued on a strobe where `last_cycle` is low.
- R3: No call is issued on a strobe where `reti_exec` or `ie_ip_write` is high. A pending request is vectored on the next qualifying final cycle.
- R4: The decision on a strobe uses the flags registered on the previous strobe. A flag that first appears on the deciding strobe is not acted on until the strobe after.
- R5: A request that is denied and has gone inactive by the next strobe is not vectored later. Nothing about a denied request is remembered.
- R6: A source is eligible only when `glob_en` is high and its bit in `src_en` is high.
- R7: A source whose `prio_hi` bit is 1 wins over any low source. Within one level, the lowest index wins.
- R8: While `inprog_hi` is set, no call is made. While only `inprog_lo` is set, only high-level sources are vectored. Granting sets the in-progress flag of the granted level.
- R9: A strobe with `last_cycle` and `reti_exec` both high clears `inprog_hi` if it is set, and otherwise clears `inprog_lo`. A strobe without `reti_exec` leaves both flags unchanged.
- R10: `flag_clr` has the granted source's bit set, in the call cycle, for tmr0 and tmr1 always and for ext0/ext1 only when the matching edge-mode input is 1. It is 0 for serial, timer 2 and counter array.
- R11: The serial request is rx OR tx, the timer 2 request is overflow OR external, and the counter-array request is overflow OR any compare flag.
- R12: `ack` is one-hot on the granted source while `call_req` is high and zero otherwise. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_strobe | input | 1 | One-clock pulse marking the sample point of a machine cycle |
| last_cycle | input | 1 | Current machine cycle is the final cycle of the instruction |
| reti_exec | input | 1 | Instruction in progress is an interrupt-return |
| ie_ip_write | input | 1 | Instruction in progress writes the enable or priority register |
| glob_en | input | 1 | Global interrupt enable |
| src_en | input | 7 | Per-source enables, bit i for source i |
| prio_hi | input | 7 | Per-source priority, 1 = high level |
| ext0_edge | input | 1 | External 0 is in transition mode |
| ext1_edge | input | 1 | External 1 is in transition mode |
| ext0_flag | input | 1 | External 0 request flag |
| tmr0_flag | input | 1 | Timer 0 overflow flag |
| ext1_flag | input | 1 | External 1 request flag |
| tmr1_flag | input | 1 | Timer 1 overflow flag |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| tmr2_ovf | input | 1 | Timer 2 overflow flag |
| tmr2_ext | input | 1 | Timer 2 external flag |
| pca_ovf | input | 1 | Counter array overflow flag |
| pca_cmp | input | 5 | Counter array compare flags |
| call_req | output | 1 | One-clock hardware call request |
| call_vec | output | 16 | Vector address, held until the next call |
| ack | output | 7 | One-hot acknowledge of the granted source |
| flag_clr | output | 7 | One-hot hardware flag clear |
| inprog_hi | output | 1 | High level in progress |
| inprog_lo | output | 1 | Low level in progress |

## Verification
The bench covers the timing boundaries: a flag raised on the deciding strobe itself, and a level request that drops while a return or an enable write blocks it. A design polling live flags would vector one machine cycle early, and one that latched denied requests would issue a phantom call. Nesting is driven through a low routine preempted by a high one and then unwound by two returns with a plain return in between. A tracker that cleared the wrong level, or cleared one on any return, leaves the in-progress outputs wrong. The per-source vector sweep is run in both external modes, so a clear strobe on a software-cleared source, or on a level-mode external, shows up on `flag_clr`.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int SRC_N      = 7;
    localparam int IDX_W      = $clog2(SRC_N);
    localparam int VEC_W      = 16;
    localparam logic [VEC_W-1:0] VEC_BASE   = 16'h0003;
    localparam logic [VEC_W-1:0] VEC_STRIDE = 16'h0008;

    typedef logic [SRC_N-1:0] src_mask_t;

    typedef enum logic [IDX_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4,
        SRC_TMR2 = 3'd5,
        SRC_PCA  = 3'd6
    } src_id_t;

    typedef struct packed {
        logic             valid;
        logic             hi;
        logic [IDX_W-1:0] idx;
    } grant_t;

    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] i);
        return VEC_BASE + VEC_STRIDE * VEC_W'(i);
    endfunction

    function automatic logic [IDX_W-1:0] first_set(input src_mask_t m);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int k = SRC_N - 1; k >= 0; k--) begin
            if (m[k]) r = IDX_W'(k);
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_snapshot.sv
module irq_snapshot
    import irq_vec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strobe,
    input  src_mask_t raw_req,
    output src_mask_t snap
);
    always_ff @(posedge clk) begin
        if (rst)         snap <= '0;
        else if (strobe) snap <= raw_req;
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_vec_pkg::*;
(
    input  src_mask_t req,
    input  src_mask_t en,
    input  logic      en_all,
    input  src_mask_t level_hi,
    input  logic      allow,
    input  logic      busy_hi,
    input  logic      busy_lo,
    output grant_t    gnt
);
    src_mask_t masked, hi_set, lo_set;

    always_comb begin
        masked = req & en & {SRC_N{en_all}};
        hi_set = masked & level_hi;
        lo_set = masked & ~level_hi;
        gnt    = '0;
        if (allow) begin
            if (|hi_set && !busy_hi) begin
                gnt.valid = 1'b1;
                gnt.hi    = 1'b1;
                gnt.idx   = first_set(hi_set);
            end else if (|lo_set && !busy_hi && !busy_lo) begin
                gnt.valid = 1'b1;
                gnt.hi    = 1'b0;
                gnt.idx   = first_set(lo_set);
            end
        end
    end
endmodule

// File: rtl/irq_level_tracker.sv
module irq_level_tracker (
    input  logic clk,
    input  logic rst,
    input  logic set_valid,
    input  logic set_hi,
    input  logic ret_fire,
    output logic busy_hi,
    output logic busy_lo
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_hi <= 1'b0;
            busy_lo <= 1'b0;
        end else if (set_valid) begin
            if (set_hi) busy_hi <= 1'b1;
            else        busy_lo <= 1'b1;
        end else if (ret_fire) begin
            if (busy_hi) busy_hi <= 1'b0;
            else         busy_lo <= 1'b0;
        end
    end

    // R8: a grant never lands on a level that is already blocked
    a_r8_grant_unblocked: assert property (@(posedge clk) disable iff (rst)
        set_valid |-> (!busy_hi && (set_hi || !busy_lo)));

    // R9: a return takes away exactly one level
    a_r9_ret_one_level: assert property (@(posedge clk) disable iff (rst)
        (ret_fire && !set_valid && busy_hi) |=> (!busy_hi && busy_lo == $past(busy_lo)));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter int PCA_CMP_N = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mc_strobe,
    input  logic                 last_cycle,
    input  logic                 reti_exec,
    input  logic                 ie_ip_write,
    input  logic                 glob_en,
    input  logic [SRC_N-1:0]     src_en,
    input  logic [SRC_N-1:0]     prio_hi,
    input  logic                 ext0_edge,
    input  logic                 ext1_edge,
    input  logic                 ext0_flag,
    input  logic                 tmr0_flag,
    input  logic                 ext1_flag,
    input  logic                 tmr1_flag,
    input  logic                 ser_rx,
    input  logic                 ser_tx,
    input  logic                 tmr2_ovf,
    input  logic                 tmr2_ext,
    input  logic                 pca_ovf,
    input  logic [PCA_CMP_N-1:0] pca_cmp,
    output logic                 call_req,
    output logic [VEC_W-1:0]     call_vec,
    output logic [SRC_N-1:0]     ack,
    output logic [SRC_N-1:0]     flag_clr,
    output logic                 inprog_hi,
    output logic                 inprog_lo
);
    src_mask_t raw_req, snap, hw_clr, gnt_mask;
    grant_t    gnt;
    logic      allow, ret_fire;

    always_comb begin
        raw_req           = '0;
        raw_req[SRC_EXT0] = ext0_flag;
        raw_req[SRC_TMR0] = tmr0_flag;
        raw_req[SRC_EXT1] = ext1_flag;
        raw_req[SRC_TMR1] = tmr1_flag;
        raw_req[SRC_SER]  = ser_rx | ser_tx;
        raw_req[SRC_TMR2] = tmr2_ovf | tmr2_ext;
        raw_req[SRC_PCA]  = pca_ovf | (|pca_cmp);
    end

    generate
        for (genvar g = 0; g < SRC_N; g++) begin : g_clr
            if (g == int'(SRC_EXT0)) begin : g_e0
                assign hw_clr[g] = ext0_edge;
            end else if (g == int'(SRC_EXT1)) begin : g_e1
                assign hw_clr[g] = ext1_edge;
            end else if (g == int'(SRC_TMR0) || g == int'(SRC_TMR1)) begin : g_t
                assign hw_clr[g] = 1'b1;
            end else begin : g_sw
                assign hw_clr[g] = 1'b0;
            end
        end
    endgenerate

    assign allow    = mc_strobe & last_cycle & ~reti_exec & ~ie_ip_write;
    assign ret_fire = mc_strobe & last_cycle & reti_exec;

    irq_snapshot u_snap (
        .clk(clk), .rst(rst), .strobe(mc_strobe), .raw_req(raw_req), .snap(snap)
    );

    irq_arbiter u_arb (
        .req(snap), .en(src_en), .en_all(glob_en), .level_hi(prio_hi),
        .allow(allow), .busy_hi(inprog_hi), .busy_lo(inprog_lo), .gnt(gnt)
    );

    irq_level_tracker u_lvl (
        .clk(clk), .rst(rst), .set_valid(gnt.valid), .set_hi(gnt.hi),
        .ret_fire(ret_fire), .busy_hi(inprog_hi), .busy_lo(inprog_lo)
    );

    assign gnt_mask = gnt.valid ? (src_mask_t'(1) << gnt.idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            call_req <= 1'b0;
            call_vec <= '0;
            ack      <= '0;
            flag_clr <= '0;
        end else begin
            call_req <= gnt.valid;
            ack      <= gnt_mask;
            flag_clr <= gnt_mask & hw_clr;
            if (gnt.valid) call_vec <= vec_of(gnt.idx);
        end
    end

    // R2 / R3: a call follows only a qualifying final-cycle strobe
    a_r2_boundary: assert property (@(posedge clk) disable iff (rst)
        call_req |-> $past(mc_strobe && last_cycle && !reti_exec && !ie_ip_write));

    // R12: acknowledge is one-hot with the call and silent otherwise
    a_r12_ack_onehot: assert property (@(posedge clk) disable iff (rst)
        call_req |-> ($countones(ack) == 1));
    a_r12_ack_quiet: assert property (@(posedge clk) disable iff (rst)
        !call_req |-> (ack == '0));

    // R10: clears only ever accompany the acknowledge
    a_r10_clr_subset: assert property (@(posedge clk) disable iff (rst)
        (flag_clr & ~ack) == '0);

    // R1: every vector sits on the 8-byte grid offset by 3
    a_r1_vec_grid: assert property (@(posedge clk) disable iff (rst)
        call_req |-> (call_vec[2:0] == 3'd3));
endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        mc_strobe = 0, last_cycle = 0, reti_exec = 0, ie_ip_write = 0;
    logic        glob_en = 0, ext0_edge = 0, ext1_edge = 0;
    logic [6:0]  src_en = 0, prio_hi = 0;
    logic [13:0] raw = 0;
    logic        call_req, inprog_hi, inprog_lo;
    logic [15:0] call_vec;
    logic [6:0]  ack, flag_clr;

    irq_vector_ctrl u0 (
        .clk(clk), .rst(rst), .mc_strobe(mc_strobe), .last_cycle(last_cycle),
        .reti_exec(reti_exec), .ie_ip_write(ie_ip_write), .glob_en(glob_en),
        .src_en(src_en), .prio_hi(prio_hi), .ext0_edge(ext0_edge), .ext1_edge(ext1_edge),
        .ext0_flag(raw[0]), .tmr0_flag(raw[1]), .ext1_flag(raw[2]), .tmr1_flag(raw[3]),
        .ser_rx(raw[4]), .ser_tx(raw[5]), .tmr2_ovf(raw[6]), .tmr2_ext(raw[7]),
        .pca_ovf(raw[8]), .pca_cmp(raw[13:9]),
        .call_req(call_req), .call_vec(call_vec), .ack(ack), .flag_clr(flag_clr),
        .inprog_hi(inprog_hi), .inprog_lo(inprog_lo)
    );

    int n_checks = 0, n_errors = 0;
    logic        s_call, s_hi, s_lo;
    logic [15:0] s_vec;
    logic [6:0]  s_ack, s_clr;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; raw = 0; glob_en = 1; src_en = 7'h7F; prio_hi = 0;
        ext0_edge = 1; ext1_edge = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
    endtask

    task automatic mc(input logic l, input logic r, input logic w);
        @(negedge clk);
        mc_strobe = 1; last_cycle = l; reti_exec = r; ie_ip_write = w;
        @(negedge clk);
        mc_strobe = 0; last_cycle = 0; reti_exec = 0; ie_ip_write = 0;
        s_call = call_req; s_vec = call_vec; s_ack = ack; s_clr = flag_clr;
        s_hi = inprog_hi; s_lo = inprog_lo;
    endtask

    function automatic logic [13:0] flag_for(input int i);
        case (i)
            0: return 14'h0001;
            1: return 14'h0002;
            2: return 14'h0004;
            3: return 14'h0008;
            4: return 14'h0020;   // serial via tx
            5: return 14'h0080;   // timer 2 via external flag
            default: return 14'h1000; // counter array via compare 3
        endcase
    endfunction

    task automatic t_reset();
        do_reset();
        check("R12 reset call", 32'(call_req), 0);
        check("R12 reset vec", 32'(call_vec), 0);
        check("R12 reset ack/clr", 32'({ack, flag_clr}), 0);
        check("R8 reset inprog", 32'({inprog_hi, inprog_lo}), 0);
    endtask

    task automatic t_vectors(input logic edge_mode);
        do_reset();
        ext0_edge = edge_mode; ext1_edge = edge_mode;
        for (int i = 0; i < 7; i++) begin
            logic [6:0] exp_clr;
            raw = flag_for(i);
            mc(0, 0, 0);
            raw = 0;
            mc(1, 0, 0);
            exp_clr = (i == 1 || i == 3 || (edge_mode && (i == 0 || i == 2))) ? 7'(1 << i) : 7'h0;
            check("R1 call", 32'(s_call), 1);
            check("R1 R11 vector", 32'(s_vec), 32'(16'h0003 + 16'(8 * i)));
            check("R12 ack", 32'(s_ack), 32'(1 << i));
            check("R10 flag_clr", 32'(s_clr), 32'(exp_clr));
            @(negedge clk);
            check("R1 pulse ends", 32'(call_req), 0);
            check("R1 vec held", 32'(call_vec), 32'(16'h0003 + 16'(8 * i)));
            check("R12 ack drops", 32'(ack), 0);
            mc(1, 1, 0);
            check("R9 reti clears lo", 32'(s_lo), 0);
        end
    endtask

    task automatic t_pca_ovf();
        do_reset();
        raw = 14'h0100; mc(0, 0, 0); raw = 0; mc(1, 0, 0);
        check("R11 pca overflow", 32'(s_vec), 32'h33);
        raw = 14'h0010; mc(1, 1, 0); raw = 0; mc(1, 0, 0);
        check("R11 serial rx", 32'(s_vec), 32'h23);
    endtask

    task automatic t_last();
        do_reset();
        raw = flag_for(1);
        mc(0, 0, 0);
        mc(0, 0, 0);
        check("R2 not final cycle", 32'(s_call), 0);
        raw = 0;
        mc(1, 0, 0);
        check("R2 final cycle", 32'(s_call), 1);
    endtask

    task automatic t_block();
        do_reset();
        raw = flag_for(3);
        mc(0, 0, 0);
        mc(1, 1, 0);
        check("R3 reti blocks", 32'(s_call), 0);
        mc(1, 0, 1);
        check("R3 ie/ip write blocks", 32'(s_call), 0);
        raw = 0;
        mc(1, 0, 0);
        check("R3 next instruction vectors", 32'(s_call), 1);
        check("R3 vector", 32'(s_vec), 32'h1B);
    endtask

    task automatic t_snapshot();
        do_reset();
        mc(0, 0, 0);
        raw = flag_for(0);
        mc(1, 0, 0);
        check("R4 new flag not yet seen", 32'(s_call), 0);
        raw = 0;
        mc(1, 0, 0);
        check("R4 seen one strobe later", 32'(s_call), 1);
    endtask

    task automatic t_drop();
        do_reset();
        ext0_edge = 0;
        raw = flag_for(0);
        mc(0, 0, 0);
        raw = 0;
        mc(1, 0, 1);
        check("R5 blocked", 32'(s_call), 0);
        mc(1, 0, 0);
        check("R5 dropped request", 32'(s_call), 0);
        mc(1, 0, 0);
        check("R5 still dropped", 32'({s_call, s_lo}), 0);
    endtask

    task automatic t_enables();
        do_reset();
        glob_en = 0;
        raw = flag_for(2);
        mc(0, 0, 0); mc(1, 0, 0);
        check("R6 global off", 32'(s_call), 0);
        glob_en = 1; src_en = 7'h7B;
        mc(1, 0, 0);
        check("R6 source off", 32'(s_call), 0);
        src_en = 7'h7F;
        mc(1, 0, 0);
        check("R6 enabled", 32'(s_vec), 32'h13);
        check("R6 call", 32'(s_call), 1);
    endtask

    task automatic t_priority();
        do_reset();
        prio_hi = 7'h08;
        raw = flag_for(0) | flag_for(3);
        mc(0, 0, 0); raw = 0; mc(1, 0, 0);
        check("R7 high wins", 32'(s_vec), 32'h1B);
        check("R8 sets hi", 32'({s_hi, s_lo}), 32'h2);
        do_reset();
        raw = flag_for(4) | flag_for(2) | flag_for(6);
        mc(0, 0, 0); raw = 0; mc(1, 0, 0);
        check("R7 fixed order", 32'(s_vec), 32'h13);
    endtask

    task automatic t_nesting();
        do_reset();
        prio_hi = 7'h30;
        raw = flag_for(0); mc(0, 0, 0); raw = 0; mc(1, 0, 0);
        check("R8 low granted", 32'({s_call, s_hi, s_lo}), 32'h5);
        raw = flag_for(1); mc(0, 0, 0); mc(1, 0, 0);
        check("R8 same level blocked", 32'(s_call), 0);
        raw = flag_for(1) | 14'h0010; mc(0, 0, 0); raw = 0; mc(1, 0, 0);
        check("R8 high preempts", 32'(s_vec), 32'h23);
        check("R8 both levels", 32'({s_call, s_hi, s_lo}), 32'h7);
        raw = flag_for(5); mc(0, 0, 0); raw = 0; mc(1, 0, 0);
        check("R8 high blocked while high", 32'(s_call), 0);
        mc(1, 1, 0);
        check("R9 reti clears hi only", 32'({s_hi, s_lo}), 32'h1);
        mc(1, 0, 0);
        check("R9 plain return keeps lo", 32'({s_call, s_hi, s_lo}), 32'h1);
        mc(1, 1, 0);
        check("R9 second reti clears lo", 32'({s_hi, s_lo}), 32'h0);
    endtask

    logic done = 0;

    initial begin
        t_reset();
        t_vectors(1'b1);
        t_vectors(1'b0);
        t_pca_ovf();
        t_last();
        t_block();
        t_snapshot();
        t_drop();
        t_enables();
        t_priority();
        t_nesting();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule